// File: doc/BRIEF.md
# Timer Capture Input Channel Conditioner

This block is the front end of one capture channel in a general-purpose timer. A two-bit mode field picks where capture events come from. The choices are the channel's own input, the input of the neighbouring channel, or an event from the internal trigger logic. The fourth setting marks the channel as an output, and an output channel never captures. A rising edge on the chosen source is an active event. A prescaler keeps one event out of every 1, 2, 4 or 8. On each kept event the block raises a capture strobe for one clock and stores the running timer count in a capture register.

Software reaches the block through four word-wide registers:

- Address 0 is the configuration word.
- Address 1 holds the channel enable.
- Address 2 holds the sticky capture and overcapture flags. Both are cleared by writing 1.
- Address 3 returns the last captured count.

While the channel is enabled, writes to the mode field are dropped. Turning the channel off clears the event prescaler.

Top module: `capc_cond`

## Requirements
- R1: After reset every register reads zero, the channel is in output mode with no prescaling, and the capture strobe is low.
- R2: With mode 00 (output), no edge on any input produces a capture.
- R3: An active event is a rising edge of the source picked by the mode field: 01 selects `pin_own`, 10 selects `pin_adj`, 11 selects `trig_evt`. Edges on the sources that are not selected have no effect.
- R4: Prescaler code 00, 01, 10 or 11 produces one capture per 1, 2, 4 or 8 active events, counted from the first event after the count was last cleared.
- R5: A capture raises `cap_strobe` for exactly one clock, one cycle after the clock edge that sees the rising edge. At that same point `cap_value` (also readable at address 3) takes the `cnt_val` present when the edge was seen.
- R6: While the enable bit is 0 the event count is held at zero and no capture occurs.
- R7: A write to address 0 leaves the mode field unchanged while the enable bit is 1. The prescaler and filter fields are written in either case.
- R8: A new prescaler code applies immediately. If the event count already reaches or exceeds the new terminal value (2^code − 1), the next event captures.
- R9: The configuration word holds the prescaler in bits [19:18], the mode in bits [17:16] and a stored, unused filter nibble in bits [3:0]. All other bits read zero.
- R10: Status bit 0 is set by every capture. Bit 1 is set by a capture that occurs while bit 0 is already set. Writing 1 to either bit clears it, and a capture in the same cycle takes priority.
- R11: The control register at address 1 holds the enable in bit 0. Register reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 control, 2 status, 3 capture) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pin_own | input | 1 | Channel's own input, already synchronous |
| pin_adj | input | 1 | Neighbouring channel's input, already synchronous |
| trig_evt | input | 1 | Internal trigger event, already synchronous |
| cnt_val | input | CW | Free-running timer count |
| cap_strobe | output | 1 | One-clock capture pulse |
| cap_value | output | CW | Last captured count |

## Verification
The assertions assume that all three source inputs and the count are already synchronous to `clk` and never unknown after reset. They also assume that a rising edge needs at least one low sample before it, so two captures can never come on consecutive clocks. The bench changes every input one nanosecond after a rising clock edge and holds each source pulse high for one whole cycle followed by at least one low cycle. This keeps every edge sampled exactly once. The reset is held for several cycles, well beyond the two-flop release, before any stimulus starts.

// File: rtl/capc_pkg.sv
package capc_pkg;
  typedef enum logic [1:0] {
    SRC_OUT  = 2'd0,
    SRC_OWN  = 2'd1,
    SRC_ADJ  = 2'd2,
    SRC_TRIG = 2'd3
  } src_sel_e;

  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 2;
  localparam int unsigned PSC_W    = 2;
  localparam int unsigned PSC_LSB  = 18;
  localparam int unsigned SEL_LSB  = 16;
  localparam int unsigned FILT_W   = 4;
  localparam int unsigned EVC_W    = 3;

  localparam logic [AW-1:0] A_CFG  = 2'd0;
  localparam logic [AW-1:0] A_CTL  = 2'd1;
  localparam logic [AW-1:0] A_STS  = 2'd2;
  localparam logic [AW-1:0] A_CAP  = 2'd3;
endpackage

// File: rtl/capc_regs.sv
module capc_regs
  import capc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              fire,
  input  logic [CW-1:0]     cap_value,
  output src_sel_e          sel,
  output logic [PSC_W-1:0]  psc,
  output logic              en,
  output logic              flag,
  output logic              ovr,
  output logic [DW-1:0]     rdata
);
  logic [FILT_W-1:0] filt_q, filt_n;
  logic [PSC_W-1:0]  psc_q, psc_n;
  src_sel_e          sel_q, sel_n;
  logic              en_q, en_n, flag_q, flag_n, ovr_q, ovr_n;
  logic              wr_cfg, wr_ctl, wr_sts;
  logic              unused_wbits;

  assign wr_cfg = wr && (addr == A_CFG);
  assign wr_ctl = wr && (addr == A_CTL);
  assign wr_sts = wr && (addr == A_STS);
  assign unused_wbits = ^{wdata[DW-1:PSC_LSB+PSC_W], wdata[SEL_LSB-1:FILT_W]};

  always_comb begin
    filt_n = filt_q;
    psc_n  = psc_q;
    sel_n  = sel_q;
    en_n   = en_q;
    flag_n = flag_q;
    ovr_n  = ovr_q;
    if (wr_cfg) begin
      filt_n = wdata[FILT_W-1:0];
      psc_n  = wdata[PSC_LSB +: PSC_W];
      if (!en_q) sel_n = src_sel_e'(wdata[SEL_LSB +: 2]);
    end
    if (wr_ctl) en_n = wdata[0];
    if (wr_sts && wdata[0]) flag_n = 1'b0;
    if (wr_sts && wdata[1]) ovr_n  = 1'b0;
    if (fire) begin
      flag_n = 1'b1;
      if (flag_q) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      psc_q  <= '0;
      sel_q  <= SRC_OUT;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      filt_q <= filt_n;
      psc_q  <= psc_n;
      sel_q  <= sel_n;
      en_q   <= en_n;
      flag_q <= flag_n;
      ovr_q  <= ovr_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CFG: begin
        rdata[FILT_W-1:0]       = filt_q;
        rdata[PSC_LSB +: PSC_W] = psc_q;
        rdata[SEL_LSB +: 2]     = sel_q;
      end
      A_CTL: rdata[0] = en_q;
      A_STS: rdata[1:0] = {ovr_q, flag_q};
      default: rdata[CW-1:0] = cap_value;
    endcase
  end

  assign sel  = sel_q;
  assign psc  = psc_q;
  assign en   = en_q;
  assign flag = flag_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/capc_src_edge.sv
module capc_src_edge
  import capc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e sel,
  input  logic     en,
  input  logic     pin_own,
  input  logic     pin_adj,
  input  logic     trig_evt,
  output logic     evt
);
  logic src, prev_q;

  always_comb begin
    unique case (sel)
      SRC_OWN:  src = pin_own;
      SRC_ADJ:  src = pin_adj;
      SRC_TRIG: src = trig_evt;
      default:  src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= src;
  end

  assign evt = en && (sel != SRC_OUT) && src && !prev_q;
endmodule

// File: rtl/capc_presc.sv
module capc_presc
  import capc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [PSC_W-1:0] psc,
  input  logic [CW-1:0]    cnt_val,
  output logic             fire,
  output logic [EVC_W-1:0] evt_cnt,
  output logic             strobe,
  output logic [CW-1:0]    cap_value
);
  logic [EVC_W-1:0] cnt_q, cnt_n, term;
  logic             stb_q;
  logic [CW-1:0]    cap_q;
  logic             cap_ld;

  assign term   = EVC_W'((1 << psc) - 1);
  assign fire   = evt && (cnt_q >= term);
  assign cap_ld = fire;

  always_comb begin
    cnt_n = cnt_q;
    if (!en)       cnt_n = '0;
    else if (fire) cnt_n = '0;
    else if (evt)  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      stb_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_ld) cap_q <= cnt_val;
  end

  assign evt_cnt   = cnt_q;
  assign strobe    = stb_q;
  assign cap_value = cap_q;
endmodule

// File: rtl/capc_cond.sv
module capc_cond
  import capc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          pin_own,
  input  logic          pin_adj,
  input  logic          trig_evt,
  input  logic [CW-1:0] cnt_val,
  output logic          cap_strobe,
  output logic [CW-1:0] cap_value
);
  logic             rst_s1_q, rst_sync_n;
  src_sel_e         sel;
  logic [PSC_W-1:0] psc;
  logic             en, flag, ovr, evt, fire;
  logic [EVC_W-1:0] evt_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  capc_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .fire(fire), .cap_value(cap_value),
    .sel(sel), .psc(psc), .en(en), .flag(flag), .ovr(ovr),
    .rdata(reg_rdata)
  );

  capc_src_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel), .en(en),
    .pin_own(pin_own), .pin_adj(pin_adj), .trig_evt(trig_evt), .evt(evt)
  );

  capc_presc #(.CW(CW)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .evt(evt), .psc(psc),
    .cnt_val(cnt_val), .fire(fire), .evt_cnt(evt_cnt),
    .strobe(cap_strobe), .cap_value(cap_value)
  );
endmodule

// File: rtl/capc_cond_chk.sv
module capc_cond_chk
  import capc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input src_sel_e         sel,
  input logic             en,
  input logic             flag,
  input logic [EVC_W-1:0] evt_cnt,
  input logic             cap_strobe,
  input logic [CW-1:0]    cap_value,
  input logic [CW-1:0]    cnt_val
);
  p_one_cycle_strobe_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_strobe |=> !cap_strobe);

  p_capture_value_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(cap_strobe) |-> (cap_value == $past(cnt_val)));

  p_output_mode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SRC_OUT) |=> !cap_strobe);

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> (!cap_strobe && evt_cnt == '0));

  p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en |=> $stable(sel));

  p_flag_follows_capture_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_strobe |-> flag);
endmodule

bind capc_cond capc_cond_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sel(sel), .en(en), .flag(flag),
  .evt_cnt(evt_cnt), .cap_strobe(cap_strobe), .cap_value(cap_value),
  .cnt_val(cnt_val)
);

// File: tb/capc_cond_bench.sv
`timescale 1ns/1ps
module capc_cond_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          pin_own = 1'b0, pin_adj = 1'b0, trig_evt = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          cap_strobe;
  logic [CW-1:0] cap_value;

  int checks = 0;
  int errors = 0;
  int strobes_seen = 0;

  always #2 clk = ~clk;

  capc_cond #(.CW(CW)) u_capc_cond (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_own(pin_own),
    .pin_adj(pin_adj), .trig_evt(trig_evt), .cnt_val(cnt_val),
    .cap_strobe(cap_strobe), .cap_value(cap_value)
  );

  // behavioural reference state
  int m_sel, m_psc, m_filt, m_en, m_prev, m_cnt, m_stb, m_cap, m_flag, m_ovr;

  always @(posedge clk) begin
    #1 cnt_val = cnt_val + 16'd37;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_psc = 0; m_filt = 0; m_en = 0; m_prev = 0;
      m_cnt = 0; m_stb = 0; m_cap = 0; m_flag = 0; m_ovr = 0;
    end else begin
      int src, ev, fi, n_sel, n_flag, n_ovr;
      src = (m_sel == 1) ? int'(pin_own) : (m_sel == 2) ? int'(pin_adj) :
            (m_sel == 3) ? int'(trig_evt) : 0;
      ev = (m_en != 0 && m_sel != 0 && src == 1 && m_prev == 0) ? 1 : 0;
      fi = (ev == 1 && m_cnt >= (1 << m_psc) - 1) ? 1 : 0;
      n_sel = m_sel; n_flag = m_flag; n_ovr = m_ovr;
      if (reg_wr && reg_addr == 2 && reg_wdata[0]) n_flag = 0;
      if (reg_wr && reg_addr == 2 && reg_wdata[1]) n_ovr = 0;
      if (fi == 1) begin n_flag = 1; if (m_flag == 1) n_ovr = 1; end
      if (reg_wr && reg_addr == 0) begin
        m_psc = int'(reg_wdata[19:18]);
        m_filt = int'(reg_wdata[3:0]);
        if (m_en == 0) n_sel = int'(reg_wdata[17:16]);
      end
      if (m_en == 0) m_cnt = 0;
      else if (fi == 1) m_cnt = 0;
      else if (ev == 1) m_cnt = m_cnt + 1;
      if (reg_wr && reg_addr == 1) m_en = int'(reg_wdata[0]);
      if (fi == 1) m_cap = int'(cnt_val);
      m_stb = fi; m_prev = src; m_sel = n_sel; m_flag = n_flag; m_ovr = n_ovr;
    end
  end

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: exp_read = (32'(m_psc) << 18) | (32'(m_sel) << 16) | 32'(m_filt);
      2'd1: exp_read = 32'(m_en);
      2'd2: exp_read = (32'(m_ovr) << 1) | 32'(m_flag);
      default: exp_read = 32'(m_cap);
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_strobe) strobes_seen++;
      check(cap_strobe == m_stb[0], "R5 strobe", longint'(cap_strobe), longint'(m_stb));
      check(cap_value == m_cap[CW-1:0], "R5 value", longint'(cap_value), longint'(m_cap));
      check(reg_rdata == exp_read(reg_addr),
            (reg_addr == 0) ? "R9 cfg" : (reg_addr == 1) ? "R11 ctl" :
            (reg_addr == 2) ? "R10 sts" : "R5 cap",
            longint'(reg_rdata), longint'(exp_read(reg_addr)));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk);
    check(reg_rdata == exp, req, longint'(reg_rdata), longint'(exp));
  endtask

  // which: 0 own, 1 adj, 2 trig
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (which == 0) pin_own = 1'b1; else if (which == 1) pin_adj = 1'b1; else trig_evt = 1'b1;
      @(posedge clk); #1;
      pin_own = 1'b0; pin_adj = 1'b0; trig_evt = 1'b0;
    end
    tick(2);
  endtask

  task automatic count_check(input int exp, input string req);
    check(strobes_seen == exp, req, longint'(strobes_seen), longint'(exp));
    strobes_seen = 0;
  endtask

  task automatic set_cfg(input int sel, input int psc);
    wreg(2'd1, 32'd0);
    wreg(2'd0, (32'(psc) << 18) | (32'(sel) << 16));
    wreg(2'd1, 32'd1);
    strobes_seen = 0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R1: reset state
    rd_check(2'd0, 32'd0, "R1 cfg");
    rd_check(2'd1, 32'd0, "R1 ctl");
    rd_check(2'd2, 32'd0, "R1 sts");
    rd_check(2'd3, 32'd0, "R1 cap");
    check(cap_strobe == 1'b0, "R1 strobe", longint'(cap_strobe), 0);

    // R2: output mode never captures
    wreg(2'd1, 32'd1);
    strobes_seen = 0;
    pulse(0, 3); pulse(1, 2); pulse(2, 2);
    count_check(0, "R2 output mode");

    // R3: source selection
    set_cfg(1, 0);
    pulse(0, 3); count_check(3, "R3 own");
    pulse(1, 2); pulse(2, 2); count_check(0, "R3 own ignores others");
    set_cfg(2, 0);
    pulse(1, 2); count_check(2, "R3 adj");
    pulse(0, 2); count_check(0, "R3 adj ignores own");
    set_cfg(3, 0);
    pulse(2, 2); count_check(2, "R3 trig");

    // R4: prescaler ratios
    set_cfg(1, 1); pulse(0, 8);  count_check(4, "R4 div2");
    set_cfg(1, 2); pulse(0, 8);  count_check(2, "R4 div4");
    set_cfg(1, 3); pulse(0, 16); count_check(2, "R4 div8");
    set_cfg(1, 3); pulse(0, 7);  count_check(0, "R4 div8 short");

    // R6: disable clears the event count
    set_cfg(1, 3);
    pulse(0, 5);
    wreg(2'd1, 32'd0);
    pulse(0, 2); count_check(0, "R6 disabled");
    wreg(2'd1, 32'd1);
    pulse(0, 7); count_check(0, "R6 count restarted");
    pulse(0, 1); count_check(1, "R6 eighth event");

    // R7: mode locked while enabled, prescaler still written
    wreg(2'd0, (32'd1 << 18) | (32'd2 << 16));
    rd_check(2'd0, (32'd1 << 18) | (32'd3 << 16) - (32'd2 << 16), "R7 lock");

    // R8: prescaler change below current count
    set_cfg(1, 3);
    pulse(0, 3);
    wreg(2'd0, (32'd1 << 18) | (32'd1 << 16));
    pulse(0, 1); count_check(1, "R8 immediate");

    // R10: flags
    wreg(2'd2, 32'd3);
    rd_check(2'd2, 32'd0, "R10 cleared");
    set_cfg(1, 0);
    pulse(0, 1);
    rd_check(2'd2, 32'd1, "R10 flag");
    pulse(0, 1);
    rd_check(2'd2, 32'd3, "R10 overcapture");
    wreg(2'd2, 32'd1);
    rd_check(2'd2, 32'd2, "R10 w1c flag");
    wreg(2'd2, 32'd2);
    rd_check(2'd2, 32'd0, "R10 w1c ovr");

    // R9: layout of the configuration word
    wreg(2'd1, 32'd0);
    wreg(2'd0, 32'hFFFF_FFFF);
    rd_check(2'd0, 32'h000F_000F, "R9 layout");
    rd_check(2'd1, 32'd0, "R11 ctl");

    tick(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule